// File: doc/BRIEF.md
# Sampling Window Tuning Search Engine

This block is a hardware sequencer that finds a good sampling-delay tap for a high-speed card interface. After a start request, it steps the delay tap upward from zero. For each tap it first asks the delay line to apply the tap. If that succeeds, it asks the command engine to run one tuning-block test and then takes the pass/fail verdict. While it sweeps, it tracks the longest run of adjacent passing taps.

When the sweep ends, the engine applies the tap at the middle of the longest passing run and then reports completion with the chosen tap. If no tap passed, it raises an error and applies no tap. The search runs only when the interface is in its 200 MHz single-data-rate timing mode. In every other mode a start request has no effect. Building the tuning command and comparing its data are left to the command engine.

Top module: `tune_search`

## Requirements
- R1: After an accepted start, the engine applies taps 0, 1, ..., 39 in ascending order, one at a time. It issues at most one test per tap, so a sweep in which every apply succeeds issues exactly 40 tests.
- R2: `tapApply` stays high until `tapAck` is sampled high, and `tapApplyErr` is valid together with `tapAck`. A test request (`testReq` held high until `testDone`) follows only an apply that completed without error. `tapApply` and `testReq` are never high at the same time.
- R3: A tap counts as failing when either its apply reports an error or its test returns `testPass`=0. A failing tap resets the current run length to zero, and a passing tap adds one to it.
- R4: The best run is replaced only when the current run becomes strictly longer than it. Of several runs with the same greatest length, the earliest one is kept.
- R5: The chosen tap equals the last tap of the best run minus floor(best length / 2).
- R6: If no tap passed, `error` is high for exactly one cycle and `done` stays low. No apply is issued after the 40th sweep step.
- R7: A start request while `hs200Mode`=0 is ignored: `busy`, `testReq`, `tapApply` and `done` all stay low.
- R8: After the apply of the chosen tap is acknowledged without error, `done` is high for exactly one cycle. `chosenTap` then holds the chosen value until the next accepted start, and the apply count of that run is 41.
- R9: After reset, `busy`, `done`, `error`, `testReq` and `tapApply` are low, and `tapValue` and `chosenTap` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs200Mode | input | 1 | 1 when the interface is in the 200 MHz SDR timing mode |
| start | input | 1 | Start a tuning search (accepted only while idle and in that mode) |
| tapValue | output | 6 | Tap presented to the delay line |
| tapApply | output | 1 | Request to apply `tapValue` |
| tapAck | input | 1 | Apply completed |
| tapApplyErr | input | 1 | Apply failed; valid together with `tapAck` |
| testReq | output | 1 | Request one tuning-block test |
| testDone | input | 1 | Test completed |
| testPass | input | 1 | Test passed; valid together with `testDone` |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle pulse: the chosen tap has been applied |
| error | output | 1 | One-cycle pulse: no passing tap was found |
| chosenTap | output | 6 | Tap chosen by the last successful search |

## Verification
Two situations are hard to bring about from the ports. One is a tie between two passing runs of equal length. The other is a tap whose apply fails in the middle of a run that would otherwise be the longest. A bench-side responder answers each apply and test handshake from per-tap pass and apply-error masks. The vector table therefore sets up equal-length runs and splits a run with an apply error. The all-pass case, the no-pass case and single passing taps at the two ends of the sweep cover the boundaries of the centre arithmetic.

// File: rtl/tune_search_pkg.sv
package tune_search_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_APPLY,
    ST_TEST,
    ST_STEP,
    ST_EVAL,
    ST_PROG
  } tuneState_t;

  typedef struct packed {
    logic clear;
    logic stepPass;
    logic stepFail;
    logic advance;
    logic loadCentre;
    logic capture;
  } tuneStrobes_t;

endpackage

// File: rtl/tune_search_dp.sv
module tune_search_dp
  import tune_search_pkg::*;
#(
  parameter int TAP_W    = 6,
  parameter int NUM_TAPS = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  tuneStrobes_t       strb,
  output logic [TAP_W-1:0]   tapReg,
  output logic [TAP_W-1:0]   chosenReg,
  output logic               isLast,
  output logic               noneFound
);
  localparam int LEN_W    = $clog2(NUM_TAPS + 1);
  localparam int LAST_TAP = NUM_TAPS - 1;

  logic [TAP_W-1:0] idx;
  logic [TAP_W-1:0] endTap;
  logic [LEN_W-1:0] curLen;
  logic [LEN_W-1:0] bestLen;
  logic [LEN_W-1:0] curNext;
  logic [TAP_W-1:0] centre;

  assign curNext   = curLen + LEN_W'(1);
  assign centre    = endTap - TAP_W'(bestLen >> 1);
  assign isLast    = (idx == TAP_W'(LAST_TAP));
  assign noneFound = (bestLen == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= '0;
      endTap    <= '0;
      curLen    <= '0;
      bestLen   <= '0;
      tapReg    <= '0;
      chosenReg <= '0;
    end else if (strb.clear) begin
      idx       <= '0;
      endTap    <= '0;
      curLen    <= '0;
      bestLen   <= '0;
      tapReg    <= '0;
      chosenReg <= '0;
    end else begin
      if (strb.stepPass) begin
        curLen <= curNext;
        if (curNext > bestLen) begin
          bestLen <= curNext;
          endTap  <= idx;
        end
      end
      if (strb.stepFail) curLen <= '0;
      if (strb.advance) begin
        idx    <= idx + TAP_W'(1);
        tapReg <= idx + TAP_W'(1);
      end
      if (strb.loadCentre) tapReg <= centre;
      if (strb.capture) chosenReg <= tapReg;
    end
  end

  AST_TAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tapReg <= TAP_W'(LAST_TAP)); // R1

  AST_BEST_NEVER_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.clear |=> bestLen >= $past(bestLen)); // R4

  AST_FAIL_ZEROES_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.stepFail && !strb.clear) |=> curLen == '0); // R3

endmodule

// File: rtl/tune_search_ctrl.sv
module tune_search_ctrl
  import tune_search_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hs200Mode,
  input  logic         start,
  input  logic         tapAck,
  input  logic         tapApplyErr,
  input  logic         testDone,
  input  logic         testPass,
  input  logic         isLast,
  input  logic         noneFound,
  output tuneStrobes_t strb,
  output logic         tapApply,
  output logic         testReq,
  output logic         busy,
  output logic         done,
  output logic         error
);
  tuneState_t state, nextState;
  logic doneSet, errSet;

  always_comb begin
    nextState = state;
    strb      = '0;
    doneSet   = 1'b0;
    errSet    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start && hs200Mode) begin
          strb.clear = 1'b1;
          nextState  = ST_APPLY;
        end
      end
      ST_APPLY: begin
        if (tapAck) begin
          if (tapApplyErr) begin
            strb.stepFail = 1'b1;
            nextState     = ST_STEP;
          end else begin
            nextState = ST_TEST;
          end
        end
      end
      ST_TEST: begin
        if (testDone) begin
          if (testPass) strb.stepPass = 1'b1;
          else          strb.stepFail = 1'b1;
          nextState = ST_STEP;
        end
      end
      ST_STEP: begin
        if (isLast) begin
          nextState = ST_EVAL;
        end else begin
          strb.advance = 1'b1;
          nextState    = ST_APPLY;
        end
      end
      ST_EVAL: begin
        if (noneFound) begin
          errSet    = 1'b1;
          nextState = ST_IDLE;
        end else begin
          strb.loadCentre = 1'b1;
          nextState       = ST_PROG;
        end
      end
      ST_PROG: begin
        if (tapAck) begin
          if (tapApplyErr) begin
            errSet = 1'b1;
          end else begin
            strb.capture = 1'b1;
            doneSet      = 1'b1;
          end
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      state <= nextState;
      done  <= doneSet;
      error <= errSet;
    end
  end

  assign tapApply = (state == ST_APPLY) || (state == ST_PROG);
  assign testReq  = (state == ST_TEST);
  assign busy     = (state != ST_IDLE);

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(tapApply && testReq)); // R2

  AST_TEST_AFTER_GOOD_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(testReq) |-> $past(tapAck && !tapApplyErr)); // R2

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !hs200Mode) |=> !busy); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_ERROR_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error)); // R6

endmodule

// File: rtl/tune_search.sv
module tune_search
  import tune_search_pkg::*;
#(
  parameter int TAP_W    = 6,
  parameter int NUM_TAPS = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs200Mode,
  input  logic             start,
  output logic [TAP_W-1:0] tapValue,
  output logic             tapApply,
  input  logic             tapAck,
  input  logic             tapApplyErr,
  output logic             testReq,
  input  logic             testDone,
  input  logic             testPass,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic [TAP_W-1:0] chosenTap
);
  tuneStrobes_t strb;
  logic isLast, noneFound;

  tune_search_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .hs200Mode  (hs200Mode),
    .start      (start),
    .tapAck     (tapAck),
    .tapApplyErr(tapApplyErr),
    .testDone   (testDone),
    .testPass   (testPass),
    .isLast     (isLast),
    .noneFound  (noneFound),
    .strb       (strb),
    .tapApply   (tapApply),
    .testReq    (testReq),
    .busy       (busy),
    .done       (done),
    .error      (error)
  );

  tune_search_dp #(
    .TAP_W   (TAP_W),
    .NUM_TAPS(NUM_TAPS)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .tapReg   (tapValue),
    .chosenReg(chosenTap),
    .isLast   (isLast),
    .noneFound(noneFound)
  );

endmodule

// File: tb/tune_search_tb.sv
module tune_search_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs200Mode = 1'b0;
  logic start = 1'b0;
  logic [5:0] tapValue;
  logic tapApply, tapAck, tapApplyErr;
  logic testReq, testDone, testPass;
  logic busy, done, error;
  logic [5:0] chosenTap;

  always #5 clk = ~clk;

  tune_search u_dut (
    .clk(clk), .rst_n(rst_n), .hs200Mode(hs200Mode), .start(start),
    .tapValue(tapValue), .tapApply(tapApply), .tapAck(tapAck),
    .tapApplyErr(tapApplyErr), .testReq(testReq), .testDone(testDone),
    .testPass(testPass), .busy(busy), .done(done), .error(error),
    .chosenTap(chosenTap)
  );

  typedef struct packed {
    logic [39:0] passMask;
    logic [39:0] errMask;
    logic [5:0]  expTap;
    logic        expErr;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{40'hFF_FFFF_FFFF, 40'h0,  6'd19, 1'b0},  // all pass
    '{40'h00_0000_0000, 40'h0,  6'd0,  1'b1},  // none pass
    '{40'h00_0000_0001, 40'h0,  6'd0,  1'b0},  // only tap 0
    '{40'h80_0000_0000, 40'h0,  6'd39, 1'b0},  // only tap 39
    '{40'h00_3FF0_7FE0, 40'h0,  6'd9,  1'b0},  // tie 5..14 vs 20..29
    '{40'h0F_C000_1C00, 40'h0,  6'd32, 1'b0},  // later longer run wins
    '{40'h00_0000_0003, 40'h0,  6'd0,  1'b0},  // taps 0..1
    '{40'h00_0030_003C, 40'h10, 6'd2,  1'b0}   // apply error at tap 4 splits run
  };

  logic [39:0] passMask = '0;
  logic [39:0] errMask  = '0;
  int errors = 0;
  int checks = 0;
  int applyCnt = 0, testCnt = 0, doneCnt = 0, errCnt = 0;
  int lastTestTap = -1;
  int orderBad = 0;
  int cycles = 0;
  logic prevApply = 1'b0, prevTest = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // responder and monitor, acting on falling edges
  initial begin
    tapAck = 0; tapApplyErr = 0; testDone = 0; testPass = 0;
    forever begin
      @(negedge clk);
      cycles++;
      if (tapApply && !prevApply) applyCnt++;
      if (testReq && !prevTest) begin
        testCnt++;
        if (int'(tapValue) <= lastTestTap) orderBad++;
        lastTestTap = int'(tapValue);
      end
      if (done) doneCnt++;
      if (error) errCnt++;
      prevApply = tapApply;
      prevTest  = testReq;
      if (tapAck) begin
        tapAck = 0; tapApplyErr = 0;
      end else if (tapApply) begin
        tapAck = 1; tapApplyErr = errMask[tapValue];
      end
      if (testDone) begin
        testDone = 0; testPass = 0;
      end else if (testReq) begin
        testDone = 1; testPass = passMask[tapValue];
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", cycles, 0);
    finishRun();
  end

  task automatic clearCounts();
    applyCnt = 0; testCnt = 0; doneCnt = 0; errCnt = 0;
    lastTestTap = -1; orderBad = 0;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic runVec(input int i);
    int waitCnt;
    logic [5:0] held;
    passMask = VECS[i].passMask;
    errMask  = VECS[i].errMask;
    hs200Mode = 1;
    clearCounts();
    pulseStart();
    waitCnt = 0;
    while (busy && waitCnt < 3000) begin
      @(negedge clk);
      waitCnt++;
    end
    check(waitCnt < 3000, "R1 run finished", waitCnt, 3000);
    repeat (4) @(negedge clk);
    check(orderBad == 0, "R1 ascending taps", orderBad, 0);
    if (VECS[i].errMask == '0)
      check(testCnt == 40, "R1 test count", testCnt, 40);
    else
      check(testCnt == 40 - $countones(VECS[i].errMask), "R2 failed apply skips test",
            testCnt, 40 - $countones(VECS[i].errMask));
    if (VECS[i].expErr) begin
      check(errCnt == 1, "R6 error pulse", errCnt, 1);
      check(doneCnt == 0, "R6 no done", doneCnt, 0);
      check(applyCnt == 40, "R6 no final apply", applyCnt, 40);
    end else begin
      check(errCnt == 0, "R4 no error", errCnt, 0);
      check(doneCnt == 1, "R8 done one cycle", doneCnt, 1);
      check(applyCnt == 41, "R8 apply count", applyCnt, 41);
      check(chosenTap == VECS[i].expTap, "R5 chosen tap", chosenTap, VECS[i].expTap);
      check(tapValue == VECS[i].expTap, "R5 applied tap", tapValue, VECS[i].expTap);
      held = chosenTap;
      repeat (20) @(negedge clk);
      check(chosenTap == held, "R8 chosen tap held", chosenTap, held);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!busy && !done && !error, "R9 flags after reset", {busy, done, error}, 0);
    check(!testReq && !tapApply, "R9 requests after reset", {testReq, tapApply}, 0);
    check(tapValue == 0 && chosenTap == 0, "R9 taps after reset", tapValue, 0);
    rst_n = 1;
    @(negedge clk);

    // R7 start ignored outside the 200 MHz mode
    hs200Mode = 0;
    clearCounts();
    pulseStart();
    repeat (100) @(negedge clk);
    check(!busy, "R7 not busy", busy, 0);
    check(applyCnt == 0 && testCnt == 0, "R7 no requests", applyCnt + testCnt, 0);
    check(doneCnt == 0 && errCnt == 0, "R7 no done", doneCnt, 0);

    for (int i = 0; i < NVEC; i++) runVec(i);

    // R3 / R4: after a successful run, a start in the wrong mode leaves chosenTap intact
    hs200Mode = 0;
    pulseStart();
    repeat (20) @(negedge clk);
    check(chosenTap == VECS[NVEC-1].expTap, "R7 chosen tap kept", chosenTap, VECS[NVEC-1].expTap);

    // R3: a failing test in the middle breaks a run; taps 0..9 pass except 5
    passMask = 40'h00_0000_03DF;
    errMask  = '0;
    hs200Mode = 1;
    clearCounts();
    pulseStart();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    check(chosenTap == 6'd2, "R3 fail resets run", chosenTap, 2);

    finishRun();
  end

endmodule